// File: doc/BRIEF.md
# Unpacked Floating-Point Adder/Subtractor

This block sums two floating-point values that earlier logic has already split into a class tag, a sign, a signed exponent and a mantissa with two integer bits above a parameterised fraction. It returns a result in the same split form, together with a sticky bit that records any bits lost to the right. A later stage packs and rounds that result. To subtract, the caller sets `op_sub`, which inverts the second operand's sign before the operands are combined.

The block handles the special values first, with a fixed precedence. It then aligns the exponents, collecting shifted-out bits into sticky. Operands of equal sign are added, with a one-place right shift on carry. Operands of opposite sign are subtracted without a prior magnitude compare. A wrapped difference is negated, and a difference below one is normalised left. A two-input rounding-mode code sets the sign of an exact zero. Operands arrive through a valid/ready handshake, and one registered result leaves for every accepted pair.

Top module: `fpau_addsub`

## Requirements
- R1: Class codes are 0 zero, 1 finite number, 2 infinity, 3 NaN. The operand with the larger code is treated as y. When both are NaN, a signalling first operand paired with a quiet second operand is made y; otherwise the second operand is y. A NaN y is returned with its sign, exponent, mantissa and signalling flag unchanged, and with sticky 0.
- R2: An infinite y with an infinite x of opposite sign gives the default NaN: class 3, sign 0, exponent 0, mantissa binary 01 followed by all-ones fraction, signalling flag 0, sticky 0. Any other infinite y is returned unchanged.
- R3: Two zeros give a zero with y's exponent and mantissa. Its sign is the OR of both signs when `rnd_mode` is 3 (toward minus infinity). For any other mode its sign is the AND of both signs.
- R4: When only x is zero, the result is y unchanged, with sticky 0.
- R5: For two numbers with different exponents, the result exponent is the larger one. The smaller operand is shifted right by the difference, and every bit shifted out is ORed into the result sticky bit.
- R6: For equal signs, the mantissas are added and the result takes x's sign. A sum of 2 or more is shifted right one place, its lost bit joins sticky, and the exponent rises by one.
- R7: For opposite signs, y is subtracted from x with sticky as borrow-in. An exactly zero difference gives class 0, exponent 0 and mantissa 0, with sign 1 only when `rnd_mode` is 3.
- R8: A wrapped difference (integer field 2 or more) is negated in two's complement and takes y's sign. `neg_fault` goes high only when this happens with unequal exponents or sticky set, so it stays low for normalised inputs.
- R9: Every finite-number result has integer field binary 01. After a subtraction, that takes a left shift with the exponent lowered by the shift count.
- R10: `op_sub` = 1 gives the same result as `op_sub` = 0 with the second operand's sign inverted.
- R11: Each pair accepted while `in_valid` and `in_ready` are high yields exactly one result, in order. `in_ready` is low while a result waits with `out_ready` low, and a waiting result holds steady.
- R12: While `rst_n` is low, `out_valid` and `in_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Operand pair can be taken |
| op_sub | input | 1 | Invert the second operand's sign |
| rnd_mode | input | 2 | Rounding mode, 3 = toward minus infinity |
| a_cls | input | 2 | First operand class |
| a_snan | input | 1 | First operand is a signalling NaN |
| a_sign | input | 1 | First operand sign |
| a_exp | input | EXP_W | First operand exponent, signed |
| a_mant | input | FRAC_W+2 | First operand mantissa |
| b_cls | input | 2 | Second operand class |
| b_snan | input | 1 | Second operand is a signalling NaN |
| b_sign | input | 1 | Second operand sign |
| b_exp | input | EXP_W | Second operand exponent, signed |
| b_mant | input | FRAC_W+2 | Second operand mantissa |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Result taken |
| r_cls | output | 2 | Result class |
| r_snan | output | 1 | Result signalling flag |
| r_sign | output | 1 | Result sign |
| r_exp | output | EXP_W | Result exponent, signed |
| r_mant | output | FRAC_W+2 | Result mantissa |
| r_sticky | output | 1 | Bits lost to the right |
| neg_fault | output | 1 | Negation taken on an illegal path |

## Verification
Each result depends only on the operand pair of its own transfer. A fault in ordering, alignment or sign choice therefore shows at the ports in the very result that follows the faulty pair: a wrong sign on a cancelled zero, a sticky bit that fails to appear, or an exponent off by the normalisation count. A handshake fault shows differently. A lost, duplicated or reordered result shifts every later comparison against the model's queue, so one mistake produces a run of mismatches that starts at the first transfer after it.

// File: rtl/fpau_pkg.sv
package fpau_pkg;
  typedef logic [1:0] cls_t;
  localparam cls_t CLS_ZERO = 2'd0;
  localparam cls_t CLS_NUM  = 2'd1;
  localparam cls_t CLS_INF  = 2'd2;
  localparam cls_t CLS_NAN  = 2'd3;
  localparam logic [1:0] RM_TO_NEG = 2'd3;
endpackage

// File: rtl/fpau_order.sv
module fpau_order
  import fpau_pkg::*;
#(
  parameter int MW = 54,
  parameter int EW = 13
) (
  input  cls_t          a_cls,
  input  logic          a_snan,
  input  logic          a_sign,
  input  logic [EW-1:0] a_exp,
  input  logic [MW-1:0] a_mant,
  input  cls_t          b_cls,
  input  logic          b_snan,
  input  logic          b_sign,
  input  logic [EW-1:0] b_exp,
  input  logic [MW-1:0] b_mant,
  output cls_t          x_cls,
  output logic          x_sign,
  output logic [EW-1:0] x_exp,
  output logic [MW-1:0] x_mant,
  output cls_t          y_cls,
  output logic          y_snan,
  output logic          y_sign,
  output logic [EW-1:0] y_exp,
  output logic [MW-1:0] y_mant
);
  logic swap;

  // heavier class goes to y; among two NaNs a lone signalling one goes to y
  always_comb begin
    swap = 1'b0;
    if (a_cls > b_cls) begin
      swap = 1'b1;
    end else if ((a_cls == CLS_NAN) && (b_cls == CLS_NAN) && a_snan && !b_snan) begin
      swap = 1'b1;
    end
  end

  assign x_cls  = swap ? b_cls  : a_cls;
  assign x_sign = swap ? b_sign : a_sign;
  assign x_exp  = swap ? b_exp  : a_exp;
  assign x_mant = swap ? b_mant : a_mant;
  assign y_cls  = swap ? a_cls  : b_cls;
  assign y_snan = swap ? a_snan : b_snan;
  assign y_sign = swap ? a_sign : b_sign;
  assign y_exp  = swap ? a_exp  : b_exp;
  assign y_mant = swap ? a_mant : b_mant;
endmodule

// File: rtl/fpau_align.sv
module fpau_align #(
  parameter int MW = 54,
  parameter int EW = 13
) (
  input  logic          x_sign,
  input  logic [EW-1:0] x_exp,
  input  logic [MW-1:0] x_mant,
  input  logic          y_sign,
  input  logic [EW-1:0] y_exp,
  input  logic [MW-1:0] y_mant,
  output logic          big_sign,
  output logic [EW-1:0] big_exp,
  output logic [MW-1:0] big_mant,
  output logic          sml_sign,
  output logic [MW-1:0] sml_mant,
  output logic          sticky,
  output logic          exp_eq
);
  localparam int SW = $clog2(MW + 1);

  logic          y_larger;
  logic [EW:0]   x_ext;
  logic [EW:0]   y_ext;
  logic [EW:0]   diff;
  logic [SW-1:0] shamt;
  logic [MW-1:0] sml_raw;
  logic [MW-1:0] lost_mask;

  assign x_ext    = {x_exp[EW-1], x_exp};
  assign y_ext    = {y_exp[EW-1], y_exp};
  assign y_larger = $signed(y_exp) > $signed(x_exp);
  assign diff     = y_larger ? (y_ext - x_ext) : (x_ext - y_ext);

  assign big_sign = y_larger ? y_sign : x_sign;
  assign big_exp  = y_larger ? y_exp  : x_exp;
  assign big_mant = y_larger ? y_mant : x_mant;
  assign sml_sign = y_larger ? x_sign : y_sign;
  assign sml_raw  = y_larger ? x_mant : y_mant;

  // a difference past the mantissa width shifts everything into sticky
  always_comb begin
    if (diff >= (EW+1)'(MW)) begin
      shamt = SW'(MW);
    end else begin
      shamt = diff[SW-1:0];
    end
  end

  assign lost_mask = ~({MW{1'b1}} << shamt);
  assign sml_mant  = sml_raw >> shamt;
  assign sticky    = |(sml_raw & lost_mask);
  assign exp_eq    = (diff == '0);
endmodule

// File: rtl/fpau_mant.sv
module fpau_mant
  import fpau_pkg::*;
#(
  parameter int MW = 54,
  parameter int EW = 13
) (
  input  logic          big_sign,
  input  logic [EW-1:0] big_exp,
  input  logic [MW-1:0] big_mant,
  input  logic          sml_sign,
  input  logic [MW-1:0] sml_mant,
  input  logic          sticky_in,
  input  logic          exp_eq,
  input  logic [1:0]    rnd_mode,
  output logic          m_sign,
  output logic [EW-1:0] m_exp,
  output logic [MW-1:0] m_mant,
  output logic          m_sticky,
  output logic          m_zero,
  output logic          m_fault
);
  logic          same_sign;
  logic [MW-1:0] sum;
  logic [MW-1:0] dif;
  logic [MW-1:0] neg_dif;
  logic          wrapped;

  assign same_sign = (big_sign == sml_sign);
  assign sum       = big_mant + sml_mant;
  assign dif       = big_mant - sml_mant - MW'(sticky_in);
  assign neg_dif   = '0 - dif;
  assign wrapped   = dif[MW-1];

  always_comb begin
    m_sign   = big_sign;
    m_exp    = big_exp;
    m_mant   = sum;
    m_sticky = sticky_in;
    m_zero   = 1'b0;
    m_fault  = 1'b0;
    if (same_sign) begin
      if (sum[MW-1]) begin
        m_mant   = sum >> 1;
        m_sticky = sticky_in | sum[0];
        m_exp    = big_exp + EW'(1);
      end
    end else if (dif == '0) begin
      m_mant = '0;
      m_zero = 1'b1;
      m_sign = (rnd_mode == RM_TO_NEG);
    end else if (wrapped) begin
      m_mant  = neg_dif;
      m_sign  = sml_sign;
      m_fault = !exp_eq || sticky_in;
    end else begin
      m_mant = dif;
    end
  end
endmodule

// File: rtl/fpau_norm.sv
module fpau_norm #(
  parameter int MW = 54,
  parameter int EW = 13
) (
  input  logic [EW-1:0] exp_i,
  input  logic [MW-1:0] mant_i,
  output logic [EW-1:0] exp_o,
  output logic [MW-1:0] mant_o
);
  localparam int SW = $clog2(MW + 1);

  logic [SW-1:0] lead_zeros;
  logic [SW-1:0] shamt;
  logic          found;

  // zeros above the leading one, counted from the top bit
  always_comb begin
    lead_zeros = '0;
    found      = 1'b0;
    for (int i = MW - 1; i >= 0; i--) begin
      if (!found) begin
        if (mant_i[i]) begin
          found = 1'b1;
        end else begin
          lead_zeros = lead_zeros + SW'(1);
        end
      end
    end
  end

  // the leading one belongs one place below the top bit
  assign shamt  = (lead_zeros == '0) ? '0 : lead_zeros - SW'(1);
  assign mant_o = mant_i << shamt;
  assign exp_o  = exp_i - EW'(shamt);
endmodule

// File: rtl/fpau_addsub.sv
module fpau_addsub
  import fpau_pkg::*;
#(
  parameter int FRAC_W = 52,
  parameter int EXP_W  = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                op_sub,
  input  logic [1:0]          rnd_mode,
  input  logic [1:0]          a_cls,
  input  logic                a_snan,
  input  logic                a_sign,
  input  logic [EXP_W-1:0]    a_exp,
  input  logic [FRAC_W+1:0]   a_mant,
  input  logic [1:0]          b_cls,
  input  logic                b_snan,
  input  logic                b_sign,
  input  logic [EXP_W-1:0]    b_exp,
  input  logic [FRAC_W+1:0]   b_mant,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [1:0]          r_cls,
  output logic                r_snan,
  output logic                r_sign,
  output logic [EXP_W-1:0]    r_exp,
  output logic [FRAC_W+1:0]   r_mant,
  output logic                r_sticky,
  output logic                neg_fault
);
  localparam int MW = FRAC_W + 2;
  localparam logic [MW-1:0] DNAN_MANT = {2'b01, {FRAC_W{1'b1}}};

  // reset release synchroniser
  logic [1:0] rst_pipe_q;
  logic       run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign run = rst_pipe_q[1];

  // operand ordering
  cls_t             x_cls, y_cls;
  logic             x_sign, y_sign, y_snan;
  logic [EXP_W-1:0] x_exp, y_exp;
  logic [MW-1:0]    x_mant, y_mant;

  fpau_order #(.MW(MW), .EW(EXP_W)) u_order (
    .a_cls (a_cls),  .a_snan(a_snan), .a_sign(a_sign), .a_exp(a_exp), .a_mant(a_mant),
    .b_cls (b_cls),  .b_snan(b_snan), .b_sign(b_sign ^ op_sub), .b_exp(b_exp), .b_mant(b_mant),
    .x_cls (x_cls),  .x_sign(x_sign), .x_exp(x_exp), .x_mant(x_mant),
    .y_cls (y_cls),  .y_snan(y_snan), .y_sign(y_sign), .y_exp(y_exp), .y_mant(y_mant)
  );

  // exponent alignment
  logic             big_sign, sml_sign, al_sticky, exp_eq;
  logic [EXP_W-1:0] big_exp;
  logic [MW-1:0]    big_mant, sml_mant;

  fpau_align #(.MW(MW), .EW(EXP_W)) u_align (
    .x_sign  (x_sign),   .x_exp(x_exp), .x_mant(x_mant),
    .y_sign  (y_sign),   .y_exp(y_exp), .y_mant(y_mant),
    .big_sign(big_sign), .big_exp(big_exp), .big_mant(big_mant),
    .sml_sign(sml_sign), .sml_mant(sml_mant),
    .sticky  (al_sticky), .exp_eq(exp_eq)
  );

  // mantissa add or subtract
  logic             m_sign, m_sticky, m_zero, m_fault;
  logic [EXP_W-1:0] m_exp;
  logic [MW-1:0]    m_mant;

  fpau_mant #(.MW(MW), .EW(EXP_W)) u_mant (
    .big_sign (big_sign), .big_exp(big_exp), .big_mant(big_mant),
    .sml_sign (sml_sign), .sml_mant(sml_mant),
    .sticky_in(al_sticky), .exp_eq(exp_eq), .rnd_mode(rnd_mode),
    .m_sign   (m_sign), .m_exp(m_exp), .m_mant(m_mant),
    .m_sticky (m_sticky), .m_zero(m_zero), .m_fault(m_fault)
  );

  // left normalisation
  logic [EXP_W-1:0] n_exp;
  logic [MW-1:0]    n_mant;

  fpau_norm #(.MW(MW), .EW(EXP_W)) u_norm (
    .exp_i (m_exp), .mant_i(m_mant),
    .exp_o (n_exp), .mant_o(n_mant)
  );

  // result selection by precedence
  cls_t             res_cls;
  logic             res_snan, res_sign, res_sticky, res_fault;
  logic [EXP_W-1:0] res_exp;
  logic [MW-1:0]    res_mant;

  always_comb begin
    res_cls    = y_cls;
    res_snan   = y_snan;
    res_sign   = y_sign;
    res_exp    = y_exp;
    res_mant   = y_mant;
    res_sticky = 1'b0;
    res_fault  = 1'b0;
    if (y_cls == CLS_NAN) begin
      res_cls = CLS_NAN;
    end else if (y_cls == CLS_INF) begin
      if ((x_cls == CLS_INF) && (x_sign != y_sign)) begin
        res_cls  = CLS_NAN;
        res_snan = 1'b0;
        res_sign = 1'b0;
        res_exp  = '0;
        res_mant = DNAN_MANT;
      end
    end else if (y_cls == CLS_ZERO) begin
      if (rnd_mode == RM_TO_NEG) begin
        res_sign = x_sign | y_sign;
      end else begin
        res_sign = x_sign & y_sign;
      end
    end else if (x_cls == CLS_ZERO) begin
      res_cls = y_cls;
    end else if (m_zero) begin
      res_cls  = CLS_ZERO;
      res_snan = 1'b0;
      res_sign = m_sign;
      res_exp  = '0;
      res_mant = '0;
    end else begin
      res_cls    = CLS_NUM;
      res_snan   = 1'b0;
      res_sign   = m_sign;
      res_exp    = n_exp;
      res_mant   = n_mant;
      res_sticky = m_sticky;
      res_fault  = m_fault;
    end
  end

  // handshake and result register
  logic in_fire;
  logic out_valid_d;

  assign in_ready = run & (~out_valid | out_ready);
  assign in_fire  = in_valid & in_ready;

  always_comb begin
    out_valid_d = out_valid;
    if (in_fire) begin
      out_valid_d = 1'b1;
    end else if (out_ready) begin
      out_valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= out_valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_cls     <= CLS_ZERO;
      r_snan    <= 1'b0;
      r_sign    <= 1'b0;
      r_exp     <= '0;
      r_mant    <= '0;
      r_sticky  <= 1'b0;
      neg_fault <= 1'b0;
    end else if (in_fire) begin
      r_cls     <= res_cls;
      r_snan    <= res_snan;
      r_sign    <= res_sign;
      r_exp     <= res_exp;
      r_mant    <= res_mant;
      r_sticky  <= res_sticky;
      neg_fault <= res_fault;
    end
  end
endmodule

// File: rtl/fpau_chk.sv
module fpau_chk #(
  parameter int MW = 54
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [1:0]    r_cls,
  input logic          r_sign,
  input logic [MW-1:0] r_mant,
  input logic          neg_fault
);
  // R11
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(r_mant) && $stable(r_cls) && $stable(r_sign));

  // R11
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R9
  norm_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (r_cls == 2'd1) |-> (r_mant[MW-1:MW-2] == 2'b01));

  // R8
  no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !neg_fault);
endmodule

bind fpau_addsub fpau_chk #(.MW(MW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .r_cls    (r_cls),
  .r_sign   (r_sign),
  .r_mant   (r_mant),
  .neg_fault(neg_fault)
);

// File: tb/tb_fpau_addsub.sv
module tb_fpau_addsub;
  localparam int CLK_PERIOD = 10;
  localparam int FRAC_W = 52;
  localparam int EXP_W  = 13;
  localparam int MW     = FRAC_W + 2;
  localparam logic [63:0] ONE = 64'd1 << FRAC_W;

  typedef struct {
    logic [1:0]  cls;
    bit          snan;
    bit          sign;
    int          exp;
    logic [63:0] mant;
  } op_t;

  typedef struct {
    logic [1:0]  cls;
    bit          snan;
    bit          sign;
    int          exp;
    logic [63:0] mant;
    bit          sticky;
    int          tag;
    bit          sub;
  } res_t;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_ready, op_sub, out_valid, out_ready;
  logic [1:0] rnd_mode, a_cls, b_cls, r_cls;
  logic a_snan, a_sign, b_snan, b_sign, r_snan, r_sign, r_sticky, neg_fault;
  logic [EXP_W-1:0] a_exp, b_exp, r_exp;
  logic [MW-1:0] a_mant, b_mant, r_mant;

  int n_chk = 0;
  int n_fail = 0;
  res_t exp_q[$];
  op_t cur_a, cur_b;
  bit cur_sub;
  logic [1:0] cur_rm;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpau_addsub #(.FRAC_W(FRAC_W), .EXP_W(EXP_W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_sub(op_sub), .rnd_mode(rnd_mode),
    .a_cls(a_cls), .a_snan(a_snan), .a_sign(a_sign), .a_exp(a_exp), .a_mant(a_mant),
    .b_cls(b_cls), .b_snan(b_snan), .b_sign(b_sign), .b_exp(b_exp), .b_mant(b_mant),
    .out_valid(out_valid), .out_ready(out_ready),
    .r_cls(r_cls), .r_snan(r_snan), .r_sign(r_sign), .r_exp(r_exp), .r_mant(r_mant),
    .r_sticky(r_sticky), .neg_fault(neg_fault)
  );

  function automatic op_t mk(logic [1:0] c, bit s, int e, logic [63:0] m, bit sn);
    op_t o;
    o.cls = c; o.sign = s; o.exp = e; o.mant = m; o.snan = sn;
    return o;
  endfunction

  // behavioural reference following the requirements
  function automatic res_t model(op_t a, op_t b, bit sub, logic [1:0] rm);
    res_t r;
    op_t x, y, t;
    int d;
    logic [63:0] ym, s;
    bit st;
    longint dd;
    b.sign = b.sign ^ sub;            // R10
    x = a; y = b;
    if (a.cls > b.cls || (a.cls == 3 && b.cls == 3 && a.snan && !b.snan)) begin
      x = b; y = a;
    end
    r.cls = y.cls; r.snan = y.snan; r.sign = y.sign; r.exp = y.exp; r.mant = y.mant;
    r.sticky = 0; r.sub = sub;
    if (y.cls == 3) begin
      r.tag = 1;                      // R1
    end else if (y.cls == 2) begin
      r.tag = 2;                      // R2
      if (x.cls == 2 && x.sign != y.sign) begin
        r.cls = 3; r.snan = 0; r.sign = 0; r.exp = 0; r.mant = (ONE << 1) - 1;
      end
    end else if (y.cls == 0) begin
      r.tag = 3;                      // R3
      r.sign = (rm == 2'd3) ? (x.sign | y.sign) : (x.sign & y.sign);
    end else if (x.cls == 0) begin
      r.tag = 4;                      // R4
    end else begin
      if (x.exp < y.exp) begin t = x; x = y; y = t; end
      d = x.exp - y.exp;
      ym = y.mant; st = 0;
      for (int i = 0; i < d && i < 70; i++) begin
        st = st | ym[0];
        ym = ym >> 1;
      end
      r.exp = x.exp; r.snan = 0; r.cls = 1;
      if (x.sign == y.sign) begin
        r.tag = 6;                    // R6
        s = x.mant + ym;
        if ((s >> (FRAC_W + 1)) != 0) begin
          st = st | s[0];
          s = s >> 1;
          r.exp = r.exp + 1;
        end
        r.mant = s; r.sign = x.sign; r.sticky = st;
      end else begin
        r.tag = 7;                    // R7
        dd = longint'(x.mant) - longint'(ym) - longint'(st);
        if (dd == 0) begin
          r.cls = 0; r.sign = (rm == 2'd3); r.exp = 0; r.mant = 0; r.sticky = 0;
        end else begin
          r.sign = x.sign;
          if (dd < 0) begin
            dd = -dd; r.sign = y.sign; r.tag = 8;   // R8
          end
          while (dd < longint'(ONE)) begin
            dd = dd << 1; r.exp = r.exp - 1; r.tag = 9;  // R9
          end
          r.mant = 64'(dd); r.sticky = st;
        end
      end
      if (d > 0 && st && r.tag == 6) r.tag = 5;     // R5
    end
    return r;
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // monitor: every cycle, after the drivers settle
  always @(negedge clk) begin
    res_t e;
    string rq;
    #1;
    if (!rst_n) begin
      n_chk++;                        // R12
      if (out_valid !== 1'b0 || in_ready !== 1'b0) begin
        n_fail++;
        $display("FAIL R12: out_valid=%0b in_ready=%0b expected 0 0", out_valid, in_ready);
      end
    end else begin
      if (in_valid && in_ready) exp_q.push_back(model(cur_a, cur_b, cur_sub, cur_rm));
      if (out_valid && out_ready) begin
        n_chk++;
        if (exp_q.size() == 0) begin
          n_fail++;                   // R11
          $display("FAIL R11: result with no accepted pair, got cls=%0d expected none", r_cls);
        end else begin
          e = exp_q.pop_front();
          rq = e.sub ? $sformatf("R10,R%0d", e.tag) : $sformatf("R%0d", e.tag);
          if (r_cls !== e.cls || r_snan !== e.snan || r_sign !== e.sign ||
              int'($signed(r_exp)) != e.exp || r_mant !== e.mant[MW-1:0] ||
              r_sticky !== e.sticky) begin
            n_fail++;
            $display("FAIL %s: got cls=%0d sn=%0b s=%0b e=%0d m=%h st=%0b expected cls=%0d sn=%0b s=%0b e=%0d m=%h st=%0b",
                     rq, r_cls, r_snan, r_sign, int'($signed(r_exp)), r_mant, r_sticky,
                     e.cls, e.snan, e.sign, e.exp, e.mant[MW-1:0], e.sticky);
          end
        end
        n_chk++;                      // R8 fault flag stays low
        if (neg_fault !== 1'b0) begin
          n_fail++;
          $display("FAIL R8: neg_fault=%0b expected 0", neg_fault);
        end
      end
    end
  end

  // consumer back-pressure
  always @(negedge clk) out_ready = ($urandom_range(3) != 0);

  task automatic send(op_t a, op_t b, bit sub, logic [1:0] rm);
    cur_a = a; cur_b = b; cur_sub = sub; cur_rm = rm;
    in_valid = 1'b1; op_sub = sub; rnd_mode = rm;
    a_cls = a.cls; a_snan = a.snan; a_sign = a.sign; a_exp = a.exp[EXP_W-1:0]; a_mant = a.mant[MW-1:0];
    b_cls = b.cls; b_snan = b.snan; b_sign = b.sign; b_exp = b.exp[EXP_W-1:0]; b_mant = b.mant[MW-1:0];
    forever begin
      #2;
      if (in_ready) begin
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  function automatic op_t rnd_op();
    int k;
    logic [63:0] f;
    k = $urandom_range(19);
    f = {32'($urandom), 32'($urandom)} & (ONE - 1);
    if (k == 0) return mk(2'd0, 1'($urandom_range(1)), 0, 0, 0);
    if (k == 1) return mk(2'd2, 1'($urandom_range(1)), 0, 0, 0);
    if (k == 2) return mk(2'd3, 1'($urandom_range(1)), 0, f | 64'd1, 1'($urandom_range(1)));
    return mk(2'd1, 1'($urandom_range(1)), int'($urandom_range(6)) - 3, ONE | f, 0);
  endfunction

  initial begin
    op_t a, b;
    rst_n = 1'b0; in_valid = 1'b0; op_sub = 0; rnd_mode = 0;
    a_cls = 0; a_snan = 0; a_sign = 0; a_exp = 0; a_mant = 0;
    b_cls = 0; b_snan = 0; b_sign = 0; b_exp = 0; b_mant = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 NaN passthrough and signalling precedence
    send(mk(3, 1, 7, ONE | 5, 0), mk(1, 0, 2, ONE, 0), 0, 0);
    send(mk(3, 0, 1, ONE | 9, 1), mk(3, 1, 2, ONE | 3, 0), 0, 0);
    send(mk(3, 0, 1, ONE | 9, 0), mk(3, 1, 2, ONE | 3, 0), 0, 0);
    // R2 infinities
    send(mk(2, 0, 0, 0, 0), mk(2, 1, 0, 0, 0), 0, 0);
    send(mk(2, 1, 0, 0, 0), mk(1, 0, 3, ONE, 0), 0, 0);
    // R10 subtract of equal infinities
    send(mk(2, 0, 0, 0, 0), mk(2, 0, 0, 0, 0), 1, 0);
    // R3 zero signs under each mode
    send(mk(0, 0, 0, 0, 0), mk(0, 1, 0, 0, 0), 0, 0);
    send(mk(0, 0, 0, 0, 0), mk(0, 1, 0, 0, 0), 0, 3);
    send(mk(0, 1, 0, 0, 0), mk(0, 1, 0, 0, 0), 0, 1);
    // R4 zero with a number
    send(mk(0, 0, 0, 0, 0), mk(1, 1, 4, ONE | 77, 0), 0, 0);
    send(mk(1, 0, -2, ONE | 12, 0), mk(0, 1, 0, 0, 0), 0, 2);
    // R6 carry renormalisation: 1.5 + 1.5
    send(mk(1, 0, 0, ONE | (ONE >> 1), 0), mk(1, 0, 0, ONE | (ONE >> 1), 0), 0, 0);
    // R5 alignment with sticky, and total shift-out
    send(mk(1, 0, 5, ONE, 0), mk(1, 0, 0, ONE | 64'h1F, 0), 0, 0);
    send(mk(1, 1, 0, ONE | 3, 0), mk(1, 1, 100, ONE, 0), 0, 0);
    // R7 exact cancellation in two modes
    send(mk(1, 0, 2, ONE | (ONE >> 2), 0), mk(1, 0, 2, ONE | (ONE >> 2), 0), 1, 0);
    send(mk(1, 0, 2, ONE | (ONE >> 2), 0), mk(1, 0, 2, ONE | (ONE >> 2), 0), 1, 3);
    // R8 wrapped difference: 1.25 - 1.75
    send(mk(1, 0, 0, ONE | (ONE >> 2), 0), mk(1, 1, 0, ONE | (ONE >> 1) | (ONE >> 2), 0), 0, 0);
    // R9 deep left shift after near cancellation
    send(mk(1, 0, 0, ONE, 0), mk(1, 1, 0, ONE | 1, 0), 0, 0);
    // R7 borrow-in from sticky across one exponent step
    send(mk(1, 0, 1, ONE, 0), mk(1, 1, 0, (ONE << 1) - 1, 0), 0, 0);
    for (int n = 0; n < 400; n++) begin
      a = rnd_op();
      b = rnd_op();
      if (a.cls == 1 && $urandom_range(3) == 0) begin
        b = a;
        b.mant = a.mant ^ 64'($urandom_range(255));
        b.sign = !a.sign;
      end
      send(a, b, 1'($urandom_range(1)), 2'($urandom_range(3)));
    end
    repeat (20) @(negedge clk);
    n_chk++;                          // R11 every accepted pair produced one result
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R11: %0d results outstanding, expected 0", exp_q.size());
    end
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R11: watchdog expired, got hang expected completion");
    summary();
  end
endmodule